// File: doc/BRIEF.md
# Optical Memory Command Packet Sequencer

This block sits on the memory-module side of a serial memory link. Each received command packet names a bank, a row, a column, a burst length and a direction. The block latches these fields and drives them onto a 25-bit address/control bus as a timed pair of commands: first a row activate, then a column read or column write.

After the column command and a CAS delay, it opens a window of data beats. A read opens a read-data-valid window and a write opens a write-enable window. The beat count is set per packet, so long streaming accesses cost no more control than short ones. A one-cycle done pulse closes every access.

The packet input is a valid/ready stream. `pkt_ready` is high only while the sequencer is idle, which includes the cycle that carries `done`. A packet is taken on a clock edge where both `pkt_valid` and `pkt_ready` are high. A packet offered while `pkt_ready` is low is not stored. The sender must hold it until `pkt_ready` returns. The beat window itself has no back-pressure: it runs on fixed DRAM timing.

Top module: `omc_seq`

## Requirements
- R1: After reset the bus carries the NOP code, `pkt_ready` is 1, and `done`, `beat_rd` and `beat_we` are 0.
- R2: A packet taken on an edge produces a row activate on the bus in the next cycle, carrying that packet's bank and row. Until the access completes, `pkt_ready` stays 0 and packets offered are neither taken nor acted on.
- R3: The column command appears exactly `T_RCD` cycles after the activate. It carries the latched bank and column, with code RD (3'b010) for a read or WR (3'b011) for a write.
- R4: The first data beat comes exactly `T_CL` cycles after the column command. Beats then run on consecutive cycles, for burst field + 1 cycles (a field value of 0 gives one beat).
- R5: During the beats of a read only `beat_rd` is high. During the beats of a write only `beat_we` is high. The two are never high together.
- R6: `done` is high for exactly one cycle, the cycle right after the last beat, and `pkt_ready` is 1 in that cycle.
- R7: In every cycle other than the activate cycle and the column-command cycle, the bus carries NOP (3'b000 with all other bits 0).
- R8: Bus layout: bits [24:22] hold the command code (NOP 000, ACT 001, RD 010, WR 011), bits [21:19] hold the bank, and bits [18:0] hold the row or column, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Command packet offered |
| pkt_ready | output | 1 | Sequencer idle, packet can be taken |
| pkt_write | input | 1 | 1 = write access, 0 = read access |
| pkt_bank | input | 3 | Bank identifier |
| pkt_burst | input | 8 | Beat count minus one |
| pkt_row | input | 16 | Row address |
| pkt_col | input | 11 | Column address |
| ac_bus | output | 25 | Address/control word toward the memory devices |
| beat_rd | output | 1 | Read data beat valid this cycle |
| beat_we | output | 1 | Write data beat enable this cycle |
| done | output | 1 | One-cycle pulse closing an access |

## Verification
Accesses are run as a read with the smallest burst (one beat), a write with a short burst, and a read with the largest burst field. Together these separate an off-by-one in the beat counter from errors in the activate-to-column and column-to-data gaps. A packet offered in the middle of an access shows whether the busy sequencer ignores input. A packet offered in the done cycle shows whether the sequencer is ready again as soon as it should be. Distinct banks, rows and columns in each access expose field swaps and errors in the bus layout.

// File: rtl/omc_pkg.sv
package omc_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'b000,
    CMD_ACT = 3'b001,
    CMD_RD  = 3'b010,
    CMD_WR  = 3'b011
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROW   = 2'd1,
    ST_CAS   = 2'd2,
    ST_BEATS = 2'd3
  } state_e;
endpackage

// File: rtl/omc_cmd_fmt.sv
module omc_cmd_fmt
  import omc_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 11,
  parameter int AC_W   = 25
) (
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              use_col,
  output logic [AC_W-1:0]   word
);
  localparam int ADDR_W = AC_W - CMD_W - BANK_W;

  logic [ADDR_W-1:0] addr;

  always_comb begin
    addr = use_col ? ADDR_W'(col) : ADDR_W'(row);
    if (cmd == CMD_NOP) word = '0;
    else                word = {cmd, bank, addr};
  end

  initial begin
    a_r8_layout_fits : assert (ADDR_W >= ROW_W && ADDR_W >= COL_W);
  end
endmodule

// File: rtl/omc_down_ctr.sv
module omc_down_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  a_r4_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/omc_seq.sv
module omc_seq
  import omc_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 11,
  parameter int BL_W   = 8,
  parameter int AC_W   = 25,
  parameter int T_RCD  = 10,
  parameter int T_CL   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic              pkt_write,
  input  logic [BANK_W-1:0] pkt_bank,
  input  logic [BL_W-1:0]   pkt_burst,
  input  logic [ROW_W-1:0]  pkt_row,
  input  logic [COL_W-1:0]  pkt_col,
  output logic [AC_W-1:0]   ac_bus,
  output logic              beat_rd,
  output logic              beat_we,
  output logic              done
);
  localparam int T_MAX = (T_RCD > T_CL) ? T_RCD : T_CL;
  localparam int CNT_W = $clog2(T_MAX + 1);

  state_e            state_q;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [BL_W-1:0]   burst_q;
  logic [AC_W-1:0]   ac_q, ac_d;
  logic              done_q;

  logic accept, t_zero, b_zero;
  logic t_load, t_dec, b_load, b_dec;
  logic [CNT_W-1:0] t_val;
  cmd_e             cmd_n;
  logic             col_go, beat_go, last_beat;

  assign accept    = pkt_valid && (state_q == ST_IDLE);
  assign col_go    = (state_q == ST_ROW) && t_zero;
  assign beat_go   = (state_q == ST_CAS) && t_zero;
  assign last_beat = (state_q == ST_BEATS) && b_zero;

  // timing counter: tRCD after accept, tCL after the column command
  assign t_load = accept || col_go;
  assign t_val  = accept ? CNT_W'(T_RCD - 1) : CNT_W'(T_CL - 1);
  assign t_dec  = ((state_q == ST_ROW) || (state_q == ST_CAS)) && !t_zero;

  omc_down_ctr #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero)
  );

  // beat counter: loaded with burst field, one beat per cycle
  assign b_load = beat_go;
  assign b_dec  = (state_q == ST_BEATS) && !b_zero;

  omc_down_ctr #(.W(BL_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .load(b_load), .load_val(burst_q),
    .dec(b_dec), .zero(b_zero)
  );

  always_comb begin
    cmd_n = CMD_NOP;
    if (accept)      cmd_n = CMD_ACT;
    else if (col_go) cmd_n = wr_q ? CMD_WR : CMD_RD;
  end

  omc_cmd_fmt #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AC_W(AC_W)
  ) u_fmt (
    .cmd(cmd_n),
    .bank(accept ? pkt_bank : bank_q),
    .row(pkt_row),
    .col(col_q),
    .use_col(!accept),
    .word(ac_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      col_q   <= '0;
      burst_q <= '0;
      ac_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      ac_q   <= ac_d;
      done_q <= last_beat;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ROW;
          wr_q    <= pkt_write;
          bank_q  <= pkt_bank;
          col_q   <= pkt_col;
          burst_q <= pkt_burst;
        end
        ST_ROW:   if (col_go)    state_q <= ST_CAS;
        ST_CAS:   if (beat_go)   state_q <= ST_BEATS;
        ST_BEATS: if (last_beat) state_q <= ST_IDLE;
        default:                 state_q <= ST_IDLE;
      endcase
    end
  end

  assign pkt_ready = (state_q == ST_IDLE);
  assign ac_bus    = ac_q;
  assign beat_rd   = (state_q == ST_BEATS) && !wr_q;
  assign beat_we   = (state_q == ST_BEATS) && wr_q;
  assign done      = done_q;

  // gap trackers for the timing properties
  logic [15:0] since_act, since_col;
  logic [CMD_W-1:0] bus_cmd;
  assign bus_cmd = ac_q[AC_W-1 -: CMD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0;
      since_col <= '0;
    end else begin
      since_act <= (bus_cmd == CMD_ACT) ? 16'd1
                 : (since_act == 16'hFFFF ? since_act : since_act + 1'b1);
      since_col <= (bus_cmd == CMD_RD || bus_cmd == CMD_WR) ? 16'd1
                 : (since_col == 16'hFFFF ? since_col : since_col + 1'b1);
    end
  end

  a_r2_act_follows : assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> (ac_bus[AC_W-1 -: CMD_W] == CMD_ACT));
  a_r3_col_gap : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_RD || bus_cmd == CMD_WR) |-> (since_act == 16'(T_RCD)));
  a_r4_cas_gap : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_rd || beat_we) |-> (since_col == 16'(T_CL)));
  a_r5_dir_excl : assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_rd && beat_we));
  a_r6_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_ready : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pkt_ready && !beat_rd && !beat_we));
endmodule

// File: tb/sim_omc_seq.sv
module sim_omc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 10;
  localparam int T_CL  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic        pkt_write = 1'b0;
  logic [2:0]  pkt_bank = '0;
  logic [7:0]  pkt_burst = '0;
  logic [15:0] pkt_row = '0;
  logic [10:0] pkt_col = '0;
  logic [24:0] ac_bus;
  logic        beat_rd, beat_we, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omc_seq #(.T_RCD(T_RCD), .T_CL(T_CL)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_write(pkt_write), .pkt_bank(pkt_bank), .pkt_burst(pkt_burst),
    .pkt_row(pkt_row), .pkt_col(pkt_col), .ac_bus(ac_bus),
    .beat_rd(beat_rd), .beat_we(beat_we), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(ac_bus == 25'd0, "R1 bus NOP", ac_bus, 0);
    chk(pkt_ready == 1'b1, "R1 ready", pkt_ready, 1);
    chk({done, beat_rd, beat_we} == 3'b000, "R1 outputs low", {done, beat_rd, beat_we}, 0);
  endtask

  // runs one access; optionally offers a stray packet mid-access and a new one in the done cycle
  task automatic run_access(input bit wr, input logic [2:0] bank, input logic [7:0] burst,
                            input logic [15:0] row, input logic [10:0] col,
                            input bit poke_busy, input bit offer_at_done);
    int act_t = -1, col_t = -1, first_t = -1, done_t = -1;
    int n_act = 0, n_col = 0, n_beats = 0, n_done = 0, n_bad = 0, n_dir = 0;
    bit gap = 0, rdy_done = 0, ready_busy_bad = 0;
    logic [24:0] act_w = '0, col_w = '0;
    int nbeat_exp = int'(burst) + 1;
    // drive packet at negedge; taken on next posedge
    pkt_valid = 1'b1; pkt_write = wr; pkt_bank = bank; pkt_burst = burst;
    pkt_row = row; pkt_col = col;
    @(negedge clk);
    pkt_valid = 1'b0;
    for (int t = 1; t < 700; t++) begin
      logic [2:0] c = ac_bus[24:22];
      if (c == 3'b001) begin n_act++; act_t = t; act_w = ac_bus; end
      else if (c == 3'b010 || c == 3'b011) begin n_col++; col_t = t; col_w = ac_bus; end
      else if (ac_bus != 25'd0) n_bad++;
      if (beat_rd || beat_we) begin
        if (first_t < 0) first_t = t;
        else if (gap) n_bad++;
        n_beats++;
        if (beat_rd == wr || beat_we != wr) n_dir++;
      end else if (first_t >= 0) gap = 1;
      if (done) begin
        n_done++; done_t = t; rdy_done = pkt_ready;
      end
      if (done_t < 0 && pkt_ready) ready_busy_bad = 1;
      if (poke_busy && t == 4) begin
        pkt_valid = 1'b1; pkt_write = !wr; pkt_bank = ~bank; pkt_row = ~row;
        pkt_col = ~col; pkt_burst = 8'd0;
      end else if (offer_at_done && done && t == done_t) begin
        pkt_valid = 1'b1; pkt_write = 1'b0; pkt_bank = 3'd6; pkt_row = 16'h0BEE;
        pkt_col = 11'h055; pkt_burst = 8'd0;
      end else pkt_valid = 1'b0;
      @(negedge clk);
      if (offer_at_done && done_t > 0 && t == done_t) begin
        chk(ac_bus == {3'b001, 3'd6, 19'h00BEE}, "R6 packet taken in done cycle", ac_bus, {3'b001, 3'd6, 19'h00BEE});
        break;
      end
      if (done_t > 0 && t >= done_t + 3) break;
    end
    pkt_valid = 1'b0;
    chk(act_t == 1, "R2 activate cycle", act_t, 1);
    chk(act_w == {3'b001, bank, 3'b000, row}, "R8 activate word", act_w, {3'b001, bank, 3'b000, row});
    chk(n_act == 1, "R2 busy packet ignored", n_act, 1);
    chk(!ready_busy_bad, "R2 ready low while busy", ready_busy_bad, 0);
    chk(col_t == 1 + T_RCD, "R3 column gap", col_t, 1 + T_RCD);
    chk(col_w == {wr ? 3'b011 : 3'b010, bank, 8'd0, col}, "R3 column word", col_w,
        {wr ? 3'b011 : 3'b010, bank, 8'd0, col});
    chk(first_t == col_t + T_CL, "R4 CAS gap", first_t, col_t + T_CL);
    chk(n_beats == nbeat_exp, "R4 beat count", n_beats, nbeat_exp);
    chk(n_dir == 0, "R5 beat direction", n_dir, 0);
    chk(n_bad == 0, "R7 NOP elsewhere / beats contiguous", n_bad, 0);
    chk(done_t == first_t + nbeat_exp && n_done == 1, "R6 done timing", done_t, first_t + nbeat_exp);
    chk(rdy_done, "R6 ready in done cycle", rdy_done, 1);
  endtask

  task automatic finish_second();
    // the access accepted in the done cycle: wait it out, expect one done
    int n_done = 0;
    for (int t = 0; t < 200; t++) begin
      if (done) n_done++;
      @(negedge clk);
    end
    chk(n_done == 1, "R6 second access completes", n_done, 1);
    chk(pkt_ready == 1'b1 && ac_bus == 25'd0, "R7 idle after access", ac_bus, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_access(1'b0, 3'd2, 8'd0,   16'hA5C3, 11'h3F1, 1'b0, 1'b0);
    run_access(1'b1, 3'd5, 8'd3,   16'h1234, 11'h0AB, 1'b1, 1'b0);
    run_access(1'b0, 3'd7, 8'd255, 16'hFFFF, 11'h7FF, 1'b0, 1'b1);
    finish_second();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule